// File: doc/BRIEF.md
# Keyed Configuration Register Space for a Multi-Function I/O Controller

This block holds the configuration registers of a multi-function I/O controller. These include a floppy controller, a parallel port, two serial ports, a real-time clock, a keyboard/mouse controller and a general I/O unit. The host reaches it through two byte-wide ports on a simple I/O bus. Address 0 is the index port and address 1 is the data port. The index port chooses a register, and the data port reads or writes it.

After reset the space is locked. The host must write a two-byte key to the index port to open it, and a single exit byte closes it again. Register indices below 0x30 are global. Indices from 0x30 upward are banked: a device-select register chooses which logical device's copy is reached. Each device bank drives that device's enable, I/O base, interrupt lines, DMA channel and mode bytes straight to the controller.

Top module: `sio_cfg_space`

## Requirements
- R1: After reset the space is locked, `bus_rdata` is 0xFF, and every device output and power-down output is zero.
- R2: The space opens only after index-port writes of 0x51 and then 0x23. `cfg_open` is high in the cycle after the 0x23 write.
- R3: While the space is locked, an index byte other than 0x23 after 0x51 cancels the partial key. A repeated 0x51 counts as a fresh first key byte, so the sequence 0x51, 0x51, 0x23 opens the space.
- R4: While the space is locked, data-port writes change no register and every read returns 0xFF.
- R5: An index-port write of 0xBB while the space is open locks it from the next cycle. All register contents are kept.
- R6: Global index 0x07 holds the full device-select byte and reads it back. Banked accesses (index 0x30 and above) reach the bank of the selected device.
- R7: Banked index 0x30 stores only bit 0, which drives `dev_enable` for the selected device. It reads back as 0x00 or 0x01.
- R8: Banked indices 0x60 and 0x61 are the high and low bytes of the 16-bit `dev_base`. Index 0x70 drives `dev_irq`, 0x72 drives `dev_irq2` and 0x74 drives `dev_dma`. All of them read back.
- R9: Banked indices 0xF0 to 0xF4 are five mode bytes per device, driven on `dev_mode` with byte m at bits [(dev*5+m)*8 +: 8]. Any other unlisted index reads 0x00 and ignores writes.
- R10: A device-select value of 9 or above reaches an empty bank. Its registers read 0x00, and writes to them change no device output.
- R11: A data write with bit 0 set to index 0x02 clears every register of every device bank at that same clock edge. It leaves the lock state, the device select and the power-down bytes unchanged. Index 0x02 always reads 0x00.
- R12: Global indices 0x22 and 0x23 are the direct and automatic power-down bytes. They read back and drive `pd_direct` and `pd_auto`.
- R13: A read strobe loads `bus_rdata` at the next clock edge, and the value holds until the next strobe. When the space is open, a read of address 0 returns the current index and a read of address 1 returns the indexed register as it was before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the index port, 1 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the space is unlocked |
| dev_enable | output | NUM_DEV | Activate bit of each device |
| dev_base | output | NUM_DEV*16 | I/O base of each device |
| dev_irq | output | NUM_DEV*8 | Primary interrupt of each device |
| dev_irq2 | output | NUM_DEV*8 | Secondary interrupt of each device |
| dev_dma | output | NUM_DEV*8 | DMA channel of each device |
| dev_mode | output | NUM_DEV*MODE_REGS*8 | Mode bytes of each device |
| pd_direct | output | 8 | Direct power-down control byte |
| pd_auto | output | 8 | Automatic power-down control byte |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next:
- the space opens only right after the second key byte,
- the exit byte locks it,
- locked reads return 0xFF,
- device enables stay frozen while the space is locked,
- a soft reset zeroes the enables,
- index 0x02 reads zero.

The key restart on a wrong or repeated byte, the banking by device select, the empty banks above device 8, and the exact byte placement on the wide device outputs can only be shown by the bench's scenarios. There, a behavioural model follows every bus access and is compared against all outputs on each clock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // key and exit codes seen on the index port
  localparam byte_t KEY_FIRST  = 8'h51;
  localparam byte_t KEY_SECOND = 8'h23;
  localparam byte_t EXIT_CODE  = 8'hBB;

  // global register indices
  localparam byte_t IDX_SOFT_RST  = 8'h02;
  localparam byte_t IDX_DEV_SEL   = 8'h07;
  localparam byte_t IDX_PD_DIRECT = 8'h22;
  localparam byte_t IDX_PD_AUTO   = 8'h23;

  // banked register indices
  localparam byte_t IDX_BANK_START = 8'h30;
  localparam byte_t IDX_ACTIVATE   = 8'h30;
  localparam byte_t IDX_BASE_HI    = 8'h60;
  localparam byte_t IDX_BASE_LO    = 8'h61;
  localparam byte_t IDX_IRQ_A      = 8'h70;
  localparam byte_t IDX_IRQ_B      = 8'h72;
  localparam byte_t IDX_DMA        = 8'h74;
  localparam byte_t IDX_MODE_FIRST = 8'hF0;

  localparam logic ADDR_INDEX = 1'b0;
  localparam logic ADDR_DATA  = 1'b1;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  idx_wr,
  input  byte_t wdata,
  output logic  open_o
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        KS_LOCKED: st_d = (wdata == KEY_FIRST) ? KS_HALF : KS_LOCKED;
        KS_HALF: begin
          if (wdata == KEY_SECOND)     st_d = KS_OPEN;
          else if (wdata == KEY_FIRST) st_d = KS_HALF;
          else                         st_d = KS_LOCKED;
        end
        KS_OPEN:   st_d = (wdata == EXIT_CODE) ? KS_LOCKED : KS_OPEN;
        default:   st_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= KS_LOCKED;
      open_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      open_o <= (st_d == KS_OPEN);
    end
  end
endmodule

// File: rtl/sio_cfg_global.sv
module sio_cfg_global
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_open,
  input  logic  idx_wr,
  input  logic  data_wr,
  input  byte_t wdata,
  output byte_t idx_q,
  output byte_t devsel_q,
  output byte_t pd_direct_q,
  output byte_t pd_auto_q,
  output logic  soft_rst_o,
  output logic  glb_hit,
  output byte_t glb_rdata
);
  logic wr_ok;
  assign wr_ok = data_wr && cfg_open;

  // soft reset acts at the same edge as the write
  assign soft_rst_o = wr_ok && (idx_q == IDX_SOFT_RST) && wdata[0];
  assign glb_hit    = (idx_q < IDX_BANK_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_wr && cfg_open && (wdata != EXIT_CODE)) begin
      idx_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devsel_q    <= '0;
      pd_direct_q <= '0;
      pd_auto_q   <= '0;
    end else if (wr_ok) begin
      case (idx_q)
        IDX_DEV_SEL:   devsel_q    <= wdata;
        IDX_PD_DIRECT: pd_direct_q <= wdata;
        IDX_PD_AUTO:   pd_auto_q   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      IDX_DEV_SEL:   glb_rdata = devsel_q;
      IDX_PD_DIRECT: glb_rdata = pd_direct_q;
      IDX_PD_AUTO:   glb_rdata = pd_auto_q;
      default:       glb_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter int MODE_REGS = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          wr_en,
  input  byte_t                         idx,
  input  byte_t                         wdata,
  output logic                          enable_o,
  output logic [2*BYTE_W-1:0]           base_o,
  output byte_t                         irq_a_o,
  output byte_t                         irq_b_o,
  output byte_t                         dma_o,
  output logic [MODE_REGS*BYTE_W-1:0]   mode_o,
  output byte_t                         rd_o
);
  byte_t base_hi_q, base_lo_q;
  byte_t mode_q [MODE_REGS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      enable_o  <= 1'b0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      irq_a_o   <= '0;
      irq_b_o   <= '0;
      dma_o     <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_ACTIVATE: enable_o  <= wdata[0];
        IDX_BASE_HI:  base_hi_q <= wdata;
        IDX_BASE_LO:  base_lo_q <= wdata;
        IDX_IRQ_A:    irq_a_o   <= wdata;
        IDX_IRQ_B:    irq_b_o   <= wdata;
        IDX_DMA:      dma_o     <= wdata;
        default: ;
      endcase
    end
  end

  assign base_o = {base_hi_q, base_lo_q};

  for (genvar m = 0; m < MODE_REGS; m++) begin : g_mode
    localparam byte_t MODE_IDX = IDX_MODE_FIRST + byte_t'(m);
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        mode_q[m] <= '0;
      end else if (wr_en && (idx == MODE_IDX)) begin
        mode_q[m] <= wdata;
      end
    end
    assign mode_o[m*BYTE_W +: BYTE_W] = mode_q[m];
  end

  always_comb begin
    rd_o = '0;
    case (idx)
      IDX_ACTIVATE: rd_o = {7'b0, enable_o};
      IDX_BASE_HI:  rd_o = base_hi_q;
      IDX_BASE_LO:  rd_o = base_lo_q;
      IDX_IRQ_A:    rd_o = irq_a_o;
      IDX_IRQ_B:    rd_o = irq_b_o;
      IDX_DMA:      rd_o = dma_o;
      default: begin
        for (int m = 0; m < MODE_REGS; m++) begin
          if (idx == IDX_MODE_FIRST + byte_t'(m)) rd_o = mode_q[m];
        end
      end
    endcase
  end
endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV   = 9,
  parameter int MODE_REGS = 5
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 bus_addr,
  input  logic                                 bus_wr,
  input  logic                                 bus_rd,
  input  logic [7:0]                           bus_wdata,
  output logic [7:0]                           bus_rdata,
  output logic                                 cfg_open,
  output logic [NUM_DEV-1:0]                   dev_enable,
  output logic [NUM_DEV*16-1:0]                dev_base,
  output logic [NUM_DEV*8-1:0]                 dev_irq,
  output logic [NUM_DEV*8-1:0]                 dev_irq2,
  output logic [NUM_DEV*8-1:0]                 dev_dma,
  output logic [NUM_DEV*MODE_REGS*8-1:0]       dev_mode,
  output logic [7:0]                           pd_direct,
  output logic [7:0]                           pd_auto
);
  localparam int BASE_W = 2 * BYTE_W;
  localparam int MODE_W = MODE_REGS * BYTE_W;

  logic  idx_wr, data_wr, soft_rst, glb_hit;
  byte_t idx_q, devsel_q, glb_rdata, bank_sel_rd, data_rd_val;
  byte_t bank_rd [NUM_DEV];

  assign idx_wr  = bus_wr && (bus_addr == ADDR_INDEX);
  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);

  sio_cfg_unlock u_unlock (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (idx_wr),
    .wdata  (bus_wdata),
    .open_o (cfg_open)
  );

  sio_cfg_global u_global (
    .clk         (clk),
    .rst         (rst),
    .cfg_open    (cfg_open),
    .idx_wr      (idx_wr),
    .data_wr     (data_wr),
    .wdata       (bus_wdata),
    .idx_q       (idx_q),
    .devsel_q    (devsel_q),
    .pd_direct_q (pd_direct),
    .pd_auto_q   (pd_auto),
    .soft_rst_o  (soft_rst),
    .glb_hit     (glb_hit),
    .glb_rdata   (glb_rdata)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    logic bank_wr;
    assign bank_wr = data_wr && cfg_open && !glb_hit && (devsel_q == byte_t'(i));

    sio_cfg_bank #(.MODE_REGS(MODE_REGS)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .clr      (soft_rst),
      .wr_en    (bank_wr),
      .idx      (idx_q),
      .wdata    (bus_wdata),
      .enable_o (dev_enable[i]),
      .base_o   (dev_base[i*BASE_W +: BASE_W]),
      .irq_a_o  (dev_irq[i*BYTE_W +: BYTE_W]),
      .irq_b_o  (dev_irq2[i*BYTE_W +: BYTE_W]),
      .dma_o    (dev_dma[i*BYTE_W +: BYTE_W]),
      .mode_o   (dev_mode[i*MODE_W +: MODE_W]),
      .rd_o     (bank_rd[i])
    );
  end

  // a select with no matching bank reads as the empty bank
  always_comb begin
    bank_sel_rd = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (devsel_q == byte_t'(i)) bank_sel_rd = bank_rd[i];
    end
  end

  assign data_rd_val = glb_hit ? glb_rdata : bank_sel_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'hFF;
    end else if (bus_rd) begin
      if (!cfg_open)                    bus_rdata <= 8'hFF;
      else if (bus_addr == ADDR_INDEX)  bus_rdata <= idx_q;
      else                              bus_rdata <= data_rd_val;
    end
  end
endmodule

// File: rtl/sio_cfg_space_chk.sv
module sio_cfg_space_chk #(
  parameter int NUM_DEV = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic               cfg_open,
  input logic [NUM_DEV-1:0] dev_enable,
  input logic [7:0]         idx_q
);
  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h23)); // R2

  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hBB |=> !cfg_open); // R5

  AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    !cfg_open && bus_rd |=> bus_rdata == 8'hFF); // R4

  AST_LOCKED_ENABLES_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(dev_enable)); // R4

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cfg_open && bus_wr && bus_addr && idx_q == 8'h02 && bus_wdata[0]
    |=> dev_enable == '0); // R11

  AST_SOFT_RESET_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_open && bus_rd && bus_addr && idx_q == 8'h02 |=> bus_rdata == 8'h00); // R11
endmodule

bind sio_cfg_space sio_cfg_space_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .cfg_open   (cfg_open),
  .dev_enable (dev_enable),
  .idx_q      (idx_q)
);

// File: tb/sio_cfg_space_tb_top.sv
module sio_cfg_space_tb_top;
  localparam int ND = 9;
  localparam int NM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_open;
  logic [ND-1:0] dev_enable;
  logic [ND*16-1:0] dev_base;
  logic [ND*8-1:0] dev_irq, dev_irq2, dev_dma;
  logic [ND*NM*8-1:0] dev_mode;
  logic [7:0] pd_direct, pd_auto;

  always #4 clk = ~clk;

  sio_cfg_space #(.NUM_DEV(ND), .MODE_REGS(NM)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
    .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq),
    .dev_irq2(dev_irq2), .dev_dma(dev_dma), .dev_mode(dev_mode),
    .pd_direct(pd_direct), .pd_auto(pd_auto)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  bit m_open, m_half;
  logic [7:0] m_idx, m_sel, m_pd22, m_pd23, m_rdata;
  logic [7:0] mb [0:ND-1][0:255];

  function automatic bit m_valid(input logic [7:0] i);
    return i == 8'h30 || i == 8'h60 || i == 8'h61 || i == 8'h70 ||
           i == 8'h72 || i == 8'h74 || (i >= 8'hF0 && i <= 8'hF4);
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] i);
    if (i == 8'h07) return m_sel;
    if (i == 8'h22) return m_pd22;
    if (i == 8'h23) return m_pd23;
    if (i < 8'h30) return 8'h00;
    if (m_sel < ND && m_valid(i)) return mb[m_sel][i];
    return 8'h00;
  endfunction

  task automatic m_clear_banks();
    for (int d = 0; d < ND; d++)
      for (int r = 0; r < 256; r++) mb[d][r] = 8'h00;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_half = 0; m_idx = 0; m_sel = 0; m_pd22 = 0; m_pd23 = 0;
      m_rdata = 8'hFF;
      m_clear_banks();
    end else begin
      if (bus_rd) begin
        if (!m_open) m_rdata = 8'hFF;
        else if (!bus_addr) m_rdata = m_idx;
        else m_rdata = m_read(m_idx);
      end
      if (bus_wr && !bus_addr) begin
        if (!m_open) begin
          if (m_half && bus_wdata == 8'h23) begin m_open = 1; m_half = 0; end
          else m_half = (bus_wdata == 8'h51);
        end else if (bus_wdata == 8'hBB) begin
          m_open = 0; m_half = 0;
        end else m_idx = bus_wdata;
      end else if (bus_wr && bus_addr && m_open) begin
        if (m_idx == 8'h02) begin if (bus_wdata[0]) m_clear_banks(); end
        else if (m_idx == 8'h07) m_sel = bus_wdata;
        else if (m_idx == 8'h22) m_pd22 = bus_wdata;
        else if (m_idx == 8'h23) m_pd23 = bus_wdata;
        else if (m_idx >= 8'h30 && m_sel < ND && m_valid(m_idx))
          mb[m_sel][m_idx] = (m_idx == 8'h30) ? {7'b0, bus_wdata[0]} : bus_wdata;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "rdata", 64'(bus_rdata), 64'(m_rdata));
      chk(cur_req, "open", 64'(cfg_open), 64'(m_open));
      chk(cur_req, "pd_direct", 64'(pd_direct), 64'(m_pd22));
      chk(cur_req, "pd_auto", 64'(pd_auto), 64'(m_pd23));
      for (int d = 0; d < ND; d++) begin
        chk(cur_req, "enable", 64'(dev_enable[d]), 64'(mb[d][8'h30][0]));
        chk(cur_req, "base", 64'(dev_base[d*16 +: 16]), 64'({mb[d][8'h60], mb[d][8'h61]}));
        chk(cur_req, "irq", 64'(dev_irq[d*8 +: 8]), 64'(mb[d][8'h70]));
        chk(cur_req, "irq2", 64'(dev_irq2[d*8 +: 8]), 64'(mb[d][8'h72]));
        chk(cur_req, "dma", 64'(dev_dma[d*8 +: 8]), 64'(mb[d][8'h74]));
        for (int m = 0; m < NM; m++)
          chk(cur_req, "mode", 64'(dev_mode[(d*NM+m)*8 +: 8]), 64'(mb[d][8'hF0 + m]));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic a, input logic w, input logic r, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask
  task automatic iw(input logic [7:0] d); cyc(1'b0, 1'b1, 1'b0, d); endtask
  task automatic dw(input logic [7:0] d); cyc(1'b1, 1'b1, 1'b0, d); endtask
  task automatic setreg(input logic [7:0] i, input logic [7:0] d); iw(i); dw(d); endtask
  task automatic getreg(input logic [7:0] i, output logic [7:0] v);
    iw(i); cyc(1'b1, 1'b0, 1'b1, 8'h00); v = bus_rdata;
  endtask

  function automatic logic [7:0] pick_idx(input int k);
    case (k % 20)
      0: return 8'h07;  1: return 8'h30;  2: return 8'h60;  3: return 8'h61;
      4: return 8'h70;  5: return 8'h72;  6: return 8'h74;  7: return 8'hF0;
      8: return 8'hF2;  9: return 8'hF4; 10: return 8'hF5; 11: return 8'h02;
      12: return 8'h22; 13: return 8'h23; 14: return 8'h31; 15: return 8'h51;
      16: return 8'hBB; 17: return 8'h07; 18: return 8'h30;
      default: return 8'h10;
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk("R1", "reset rdata", 64'(bus_rdata), 64'hFF);
    chk("R1", "reset open", 64'(cfg_open), 64'h0);
    chk("R1", "reset enables", 64'(dev_enable), 64'h0);
    chk("R1", "reset base", 64'(dev_base[15:0]), 64'h0);

    cur_req = "R4";
    dw(8'h01);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R4", "locked read", 64'(bus_rdata), 64'hFF);

    cur_req = "R3";
    iw(8'h51); iw(8'h00); iw(8'h23);
    chk("R3", "broken key stays locked", 64'(cfg_open), 64'h0);
    iw(8'h51); iw(8'h51);
    chk("R3", "half key not open", 64'(cfg_open), 64'h0);
    cur_req = "R2";
    iw(8'h23);
    chk("R2", "key opens", 64'(cfg_open), 64'h1);

    cur_req = "R7";
    setreg(8'h07, 8'h03);
    setreg(8'h30, 8'hFF);
    chk("R7", "enable dev3", 64'(dev_enable), 64'h8);
    getreg(8'h30, v);
    chk("R7", "activate readback", 64'(v), 64'h01);

    cur_req = "R8";
    setreg(8'h60, 8'h03); setreg(8'h61, 8'h78);
    setreg(8'h70, 8'h07); setreg(8'h74, 8'h03);
    chk("R8", "base dev3", 64'(dev_base[3*16 +: 16]), 64'h0378);
    chk("R8", "irq dev3", 64'(dev_irq[3*8 +: 8]), 64'h07);
    setreg(8'h07, 8'h07); setreg(8'h72, 8'h0C);
    chk("R8", "irq2 dev7", 64'(dev_irq2[7*8 +: 8]), 64'h0C);

    cur_req = "R9";
    setreg(8'hF0, 8'hBC); setreg(8'hF4, 8'h05); setreg(8'hF5, 8'h99); setreg(8'h40, 8'h11);
    chk("R9", "mode F4 dev7", 64'(dev_mode[(7*NM+4)*8 +: 8]), 64'h05);
    getreg(8'hF5, v);
    chk("R9", "unlisted reads 0", 64'(v), 64'h00);

    cur_req = "R10";
    setreg(8'h07, 8'h0C);
    setreg(8'h30, 8'h01); setreg(8'h70, 8'h05);
    getreg(8'h30, v);
    chk("R10", "empty bank read", 64'(v), 64'h00);
    chk("R10", "enables untouched", 64'(dev_enable), 64'h8);
    cur_req = "R6";
    getreg(8'h07, v);
    chk("R6", "devsel readback", 64'(v), 64'h0C);

    cur_req = "R12";
    setreg(8'h22, 8'h5A); setreg(8'h23, 8'hA5);
    chk("R12", "pd_direct", 64'(pd_direct), 64'h5A);
    getreg(8'h23, v);
    chk("R12", "pd_auto readback", 64'(v), 64'hA5);

    cur_req = "R13";
    iw(8'h61);
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R13", "index read", 64'(bus_rdata), 64'h61);
    @(negedge clk);
    chk("R13", "rdata holds", 64'(bus_rdata), 64'h61);

    cur_req = "R5";
    iw(8'hBB);
    chk("R5", "exit locks", 64'(cfg_open), 64'h0);
    cur_req = "R4";
    dw(8'h00);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R4", "locked read after exit", 64'(bus_rdata), 64'hFF);
    chk("R4", "enables kept", 64'(dev_enable), 64'h8);

    cur_req = "R11";
    iw(8'h51); iw(8'h23);
    setreg(8'h07, 8'h03);
    setreg(8'h02, 8'h01);
    chk("R11", "soft reset enables", 64'(dev_enable), 64'h0);
    chk("R11", "soft reset base", 64'(dev_base[3*16 +: 16]), 64'h0);
    chk("R11", "stays open", 64'(cfg_open), 64'h1);
    getreg(8'h02, v);
    chk("R11", "reg02 reads 0", 64'(v), 64'h00);
    getreg(8'h07, v);
    chk("R11", "devsel kept", 64'(v), 64'h03);

    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [7:0] d;
      k = int'($urandom_range(0, 99));
      d = 8'($urandom);
      if (k < 30) begin
        cyc(1'b0, 1'b1, 1'($urandom_range(0, 1)), pick_idx(int'($urandom)));
        if (!cfg_open && $urandom_range(0, 3) == 0) begin iw(8'h51); iw(8'h23); end
      end else if (k < 70) begin
        if (m_idx == 8'h07) d = 8'($urandom_range(0, 11));
        if (m_idx == 8'h02 && $urandom_range(0, 7) != 0) d[0] = 1'b0;
        cyc(1'b1, 1'b1, 1'($urandom_range(0, 1)), d);
      end else begin
        cyc(1'($urandom_range(0, 1)), 1'b0, 1'b1, 8'h00);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule